// File: doc/BRIEF.md
# Multichannel DMA Register Bank

This block is the software-visible register file of a DMA controller that has a set of write channels and a set of read channels. All channels may run at the same time. A 32-bit register bus with a single request cycle writes and reads the bank. Read data comes back one cycle after the request. The bank holds nine 32-bit configuration words per channel and drives all of them to the transfer engines at all times. It also holds a per-direction engine enable, a doorbell that turns a register write into a one-cycle start or abort pulse, and per-direction interrupt status, mask and clear registers that collect done and abort events from the engines.

The channel registers can be reached in two ways, chosen by the `map_unrolled` input. In viewport mode, a selector register names one channel, and a shared window of nine words maps onto that channel's registers. In unrolled mode, every channel has its own fixed block of addresses. Only the map of the current mode is active. The other map reads as zero and ignores writes.

Top module: `dmareg_bank`

## Requirements
- R1: After reset, every channel word, engine enable, selector, interrupt status and mask is zero, `rsp_valid` is 0 and no start, abort or interrupt output is active.
- R2: In unrolled mode, the word for channel slot s (slots 0-7 are write channels 0-7, slots 8-15 are read channels 0-7) and register index k sits at byte address 0x1000 + s*0x200 + 4*k. The register indices are: 0 control1, 1 control2, 2 transfer size, 3 source low, 4 source high, 5 destination low, 6 destination high, 7 list pointer low, 8 list pointer high. A written word appears on `wr_cfg`/`rd_cfg` and reads back with `rsp_valid` one cycle after the read request. The low and high halves of an address are independent words.
- R3: The selector at 0x40 stores bit 31 (1 = read channel, 0 = write channel) and bits 2:0 (channel index), and reads back with those fields. In viewport mode, the window at 0x100 + 4*k reaches register k of the selected channel.
- R4: With `map_unrolled`=1, the window reads zero and ignores writes. With `map_unrolled`=0, addresses 0x1000-0x2FFF read zero and ignore writes.
- R5: A channel index at or above the channel count of its direction (WR_CH or RD_CH) reads zero, ignores writes and gives no doorbell pulse.
- R6: Engine enable sits at bit 0 of 0x00 (write) and 0x20 (read). A doorbell write to 0x04 (write) or 0x24 (read) while the engine is enabled produces a pulse lasting one cycle, in the cycle after the write, on the channel given by data bits 2:0. The pulse appears on `*_start` when data bit 31 is 0 and on `*_abort` when it is 1. The doorbell reads as zero.
- R7: A doorbell write while the engine enable of its direction is 0 produces no pulse.
- R8: Interrupt status at 0x08 (write) and 0x28 (read) sets bit c on a done event and bit 16+c on an abort event of channel c. These bits stay set.
- R9: Writing ones to the clear register at 0x10 (write) or 0x30 (read) clears those status bits. The clear register reads as zero. An event in the same cycle as its clear leaves the bit set.
- R10: The mask at 0x0C (write) and 0x2C (read) uses the status layout, with 1 meaning masked. `wr_irq`/`rd_irq` is high exactly when some status bit of that direction is set and unmasked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| map_unrolled | input | 1 | 1 = flat per-channel map, 0 = selector window |
| req_valid | input | 1 | Register access this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 14 | Byte address, word aligned |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid (one cycle after a read) |
| rsp_rdata | output | 32 | Read data, held until the next read |
| wr_cfg | output | WR_CH*9*32 | Write-channel configuration words [ch][reg] |
| rd_cfg | output | RD_CH*9*32 | Read-channel configuration words [ch][reg] |
| wr_start | output | WR_CH | Write-channel start pulses |
| wr_abort | output | WR_CH | Write-channel abort pulses |
| rd_start | output | RD_CH | Read-channel start pulses |
| rd_abort | output | RD_CH | Read-channel abort pulses |
| wr_done_evt | input | WR_CH | Done events from write engines |
| wr_abort_evt | input | WR_CH | Abort events from write engines |
| rd_done_evt | input | RD_CH | Done events from read engines |
| rd_abort_evt | input | RD_CH | Abort events from read engines |
| wr_irq | output | 1 | Write-direction interrupt |
| rd_irq | output | 1 | Read-direction interrupt |

## Verification
Each result has a fixed distance from the edge that samples its stimulus. A register write shows on the configuration outputs after that same edge. A read's data and `rsp_valid` arrive one edge after the request. A doorbell pulse lasts from the edge that takes the write until the next edge. An event updates status and the interrupt line at the edge that samples it. The bench drives every input on a falling edge and samples on the following falling edge, which lies between exactly those two rising edges. Doorbell checks look again one cycle later to confirm that the pulse has ended.

// File: rtl/dmareg_pkg.sv
package dmareg_pkg;

  localparam int DATA_W      = 32;
  localparam int ADDR_W      = 14;
  localparam int MAX_CH      = 8;
  localparam int CH_IDX_W    = 3;
  localparam int REGS_PER_CH = 9;
  localparam int RSEL_W      = 4;
  localparam int ABT_LSB     = 16;

  typedef enum logic [2:0] {
    HIT_NONE,
    HIT_ENGEN,
    HIT_DBELL,
    HIT_ISTAT,
    HIT_IMASK,
    HIT_ICLR,
    HIT_VSEL,
    HIT_CHAN
  } hit_e;

  typedef struct packed {
    hit_e                hit;
    logic                dir;   // 0 write side, 1 read side
    logic [CH_IDX_W-1:0] ch;
    logic [RSEL_W-1:0]   rsel;
  } dec_t;

  // Address decode shared by both maps
  function automatic dec_t decode_addr(input logic [ADDR_W-1:0] a,
                                       input logic              unrolled,
                                       input logic              vdir,
                                       input logic [CH_IDX_W-1:0] vch);
    dec_t             d;
    logic [ADDR_W-1:0] off;
    logic [6:0]        word7;
    logic [5:0]        word6;
    d     = '{hit: HIT_NONE, dir: 1'b0, ch: '0, rsel: '0};
    off   = a - 14'h1000;
    word7 = off[8:2];
    word6 = a[7:2];
    if (a[13:12] != 2'b00) begin
      if (a[13:12] != 2'b11 && unrolled && word7 < 7'd9) begin
        d.hit  = HIT_CHAN;
        d.dir  = off[12];
        d.ch   = off[11:9];
        d.rsel = word7[3:0];
      end
    end else if (a[11:8] == 4'h1) begin
      if (!unrolled && word6 < 6'd9) begin
        d.hit  = HIT_CHAN;
        d.dir  = vdir;
        d.ch   = vch;
        d.rsel = word6[3:0];
      end
    end else if (a[11:8] == 4'h0) begin
      if (word6 == 6'h10) begin
        d.hit = HIT_VSEL;
      end else if (a[7:6] == 2'b00) begin
        d.dir = a[5];
        case (a[4:2])
          3'd0:    d.hit = HIT_ENGEN;
          3'd1:    d.hit = HIT_DBELL;
          3'd2:    d.hit = HIT_ISTAT;
          3'd3:    d.hit = HIT_IMASK;
          3'd4:    d.hit = HIT_ICLR;
          default: d.hit = HIT_NONE;
        endcase
      end
    end
    return d;
  endfunction

  // Status bits that exist for a direction with nch channels
  function automatic logic [DATA_W-1:0] chan_bits(input int nch);
    logic [DATA_W-1:0] m;
    m = '0;
    for (int i = 0; i < MAX_CH; i++) begin
      if (i < nch) begin
        m[i]           = 1'b1;
        m[ABT_LSB + i] = 1'b1;
      end
    end
    return m;
  endfunction

  function automatic logic [MAX_CH-1:0] ch_onehot(input logic [CH_IDX_W-1:0] ch);
    return MAX_CH'(1) << ch;
  endfunction

endpackage

// File: rtl/dmareg_chfile.sv
module dmareg_chfile
  import dmareg_pkg::*;
#(
  parameter int NCH = 8
) (
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic                                    we,
  input  logic [CH_IDX_W-1:0]                     ch,
  input  logic [RSEL_W-1:0]                       rsel,
  input  logic [DATA_W-1:0]                       wdata,
  output logic [DATA_W-1:0]                       rdata,
  output logic [NCH-1:0][REGS_PER_CH-1:0][DATA_W-1:0] cfg
);

  logic [DATA_W-1:0] store [NCH][REGS_PER_CH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++)
        for (int r = 0; r < REGS_PER_CH; r++)
          store[c][r] <= '0;
    end else if (we) begin
      for (int c = 0; c < NCH; c++)
        for (int r = 0; r < REGS_PER_CH; r++)
          if (ch == CH_IDX_W'(c) && rsel == RSEL_W'(r))
            store[c][r] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    for (int c = 0; c < NCH; c++)
      for (int r = 0; r < REGS_PER_CH; r++)
        if (ch == CH_IDX_W'(c) && rsel == RSEL_W'(r))
          rdata = store[c][r];
  end

  for (genvar gc = 0; gc < NCH; gc++) begin : g_ch
    for (genvar gr = 0; gr < REGS_PER_CH; gr++) begin : g_reg
      assign cfg[gc][gr] = store[gc][gr];
    end
  end

endmodule

// File: rtl/dmareg_dbell.sv
module dmareg_dbell
  import dmareg_pkg::*;
#(
  parameter int NCH = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fire,
  input  logic                code_abort,
  input  logic [CH_IDX_W-1:0] code_ch,
  output logic [NCH-1:0]      start,
  output logic [NCH-1:0]      abort
);

  localparam logic [CH_IDX_W:0] LIM = (CH_IDX_W+1)'(NCH);

  logic              ch_ok;
  logic [MAX_CH-1:0] hot;

  assign ch_ok = ({1'b0, code_ch} < LIM);
  assign hot   = ch_onehot(code_ch);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start <= '0;
      abort <= '0;
    end else begin
      start <= '0;
      abort <= '0;
      if (fire && ch_ok) begin
        if (code_abort) abort <= hot[NCH-1:0];
        else            start <= hot[NCH-1:0];
      end
    end
  end

endmodule

// File: rtl/dmareg_irq.sv
module dmareg_irq
  import dmareg_pkg::*;
#(
  parameter int NCH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    done_evt,
  input  logic [NCH-1:0]    abt_evt,
  input  logic              mask_we,
  input  logic              clr_we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] stat,
  output logic [DATA_W-1:0] mask,
  output logic              irq
);

  localparam logic [DATA_W-1:0] IMPL = chan_bits(NCH);

  logic [DATA_W-1:0] stat_set;
  logic [DATA_W-1:0] stat_clr;
  logic [DATA_W-1:0] stat_nxt;

  always_comb begin
    stat_set = '0;
    stat_set[NCH-1:0]                 = done_evt;
    stat_set[ABT_LSB+NCH-1:ABT_LSB]   = abt_evt;
  end

  assign stat_clr = clr_we ? wdata : '0;
  assign stat_nxt = ((stat & ~stat_clr) | stat_set) & IMPL;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat <= '0;
      mask <= '0;
    end else begin
      stat <= stat_nxt;
      if (mask_we) mask <= wdata & IMPL;
    end
  end

  assign irq = |(stat & ~mask);

endmodule

// File: rtl/dmareg_bank.sv
module dmareg_bank
  import dmareg_pkg::*;
#(
  parameter int WR_CH = 8,
  parameter int RD_CH = 6
) (
  input  logic                                        clk,
  input  logic                                        rst_n,
  input  logic                                        map_unrolled,
  input  logic                                        req_valid,
  input  logic                                        req_write,
  input  logic [13:0]                                 req_addr,
  input  logic [31:0]                                 req_wdata,
  output logic                                        rsp_valid,
  output logic [31:0]                                 rsp_rdata,
  output logic [WR_CH-1:0][8:0][31:0]                 wr_cfg,
  output logic [RD_CH-1:0][8:0][31:0]                 rd_cfg,
  output logic [WR_CH-1:0]                            wr_start,
  output logic [WR_CH-1:0]                            wr_abort,
  output logic [RD_CH-1:0]                            rd_start,
  output logic [RD_CH-1:0]                            rd_abort,
  input  logic [WR_CH-1:0]                            wr_done_evt,
  input  logic [WR_CH-1:0]                            wr_abort_evt,
  input  logic [RD_CH-1:0]                            rd_done_evt,
  input  logic [RD_CH-1:0]                            rd_abort_evt,
  output logic                                        wr_irq,
  output logic                                        rd_irq
);

  // Global state
  logic [1:0]          eng_en;
  logic                vsel_dir;
  logic [CH_IDX_W-1:0] vsel_ch;

  // Decoded access, brought out as named wires
  dec_t dec;
  logic bus_wr;
  logic bus_rd;
  logic wr_ch_we, rd_ch_we;
  logic wr_db_fire, rd_db_fire;
  logic wr_mask_we, rd_mask_we;
  logic wr_clr_we, rd_clr_we;

  logic [DATA_W-1:0] wr_ch_rdata, rd_ch_rdata;
  logic [DATA_W-1:0] wr_stat, rd_stat, wr_mask, rd_mask;
  logic [DATA_W-1:0] rd_mux;

  assign dec    = decode_addr(req_addr, map_unrolled, vsel_dir, vsel_ch);
  assign bus_wr = req_valid && req_write;
  assign bus_rd = req_valid && !req_write;

  assign wr_ch_we   = bus_wr && dec.hit == HIT_CHAN  && !dec.dir;
  assign rd_ch_we   = bus_wr && dec.hit == HIT_CHAN  &&  dec.dir;
  assign wr_db_fire = bus_wr && dec.hit == HIT_DBELL && !dec.dir && eng_en[0];
  assign rd_db_fire = bus_wr && dec.hit == HIT_DBELL &&  dec.dir && eng_en[1];
  assign wr_mask_we = bus_wr && dec.hit == HIT_IMASK && !dec.dir;
  assign rd_mask_we = bus_wr && dec.hit == HIT_IMASK &&  dec.dir;
  assign wr_clr_we  = bus_wr && dec.hit == HIT_ICLR  && !dec.dir;
  assign rd_clr_we  = bus_wr && dec.hit == HIT_ICLR  &&  dec.dir;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eng_en   <= '0;
      vsel_dir <= 1'b0;
      vsel_ch  <= '0;
    end else if (bus_wr) begin
      if (dec.hit == HIT_ENGEN) eng_en[dec.dir] <= req_wdata[0];
      if (dec.hit == HIT_VSEL) begin
        vsel_dir <= req_wdata[31];
        vsel_ch  <= req_wdata[CH_IDX_W-1:0];
      end
    end
  end

  dmareg_chfile #(.NCH(WR_CH)) i_wr_file (
    .clk(clk), .rst_n(rst_n), .we(wr_ch_we), .ch(dec.ch), .rsel(dec.rsel),
    .wdata(req_wdata), .rdata(wr_ch_rdata), .cfg(wr_cfg)
  );

  dmareg_chfile #(.NCH(RD_CH)) i_rd_file (
    .clk(clk), .rst_n(rst_n), .we(rd_ch_we), .ch(dec.ch), .rsel(dec.rsel),
    .wdata(req_wdata), .rdata(rd_ch_rdata), .cfg(rd_cfg)
  );

  dmareg_dbell #(.NCH(WR_CH)) i_wr_dbell (
    .clk(clk), .rst_n(rst_n), .fire(wr_db_fire), .code_abort(req_wdata[31]),
    .code_ch(req_wdata[CH_IDX_W-1:0]), .start(wr_start), .abort(wr_abort)
  );

  dmareg_dbell #(.NCH(RD_CH)) i_rd_dbell (
    .clk(clk), .rst_n(rst_n), .fire(rd_db_fire), .code_abort(req_wdata[31]),
    .code_ch(req_wdata[CH_IDX_W-1:0]), .start(rd_start), .abort(rd_abort)
  );

  dmareg_irq #(.NCH(WR_CH)) i_wr_irq (
    .clk(clk), .rst_n(rst_n), .done_evt(wr_done_evt), .abt_evt(wr_abort_evt),
    .mask_we(wr_mask_we), .clr_we(wr_clr_we), .wdata(req_wdata),
    .stat(wr_stat), .mask(wr_mask), .irq(wr_irq)
  );

  dmareg_irq #(.NCH(RD_CH)) i_rd_irq (
    .clk(clk), .rst_n(rst_n), .done_evt(rd_done_evt), .abt_evt(rd_abort_evt),
    .mask_we(rd_mask_we), .clr_we(rd_clr_we), .wdata(req_wdata),
    .stat(rd_stat), .mask(rd_mask), .irq(rd_irq)
  );

  always_comb begin
    case (dec.hit)
      HIT_ENGEN: rd_mux = {31'd0, eng_en[dec.dir]};
      HIT_ISTAT: rd_mux = dec.dir ? rd_stat : wr_stat;
      HIT_IMASK: rd_mux = dec.dir ? rd_mask : wr_mask;
      HIT_VSEL:  rd_mux = {vsel_dir, {(DATA_W-1-CH_IDX_W){1'b0}}, vsel_ch};
      HIT_CHAN:  rd_mux = dec.dir ? rd_ch_rdata : wr_ch_rdata;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= bus_rd;
      if (bus_rd) rsp_rdata <= rd_mux;
    end
  end

endmodule

// File: rtl/dmareg_bank_chk.sv
module dmareg_bank_chk #(
  parameter int WR_CH = 8,
  parameter int RD_CH = 6
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        map_unrolled,
  input logic                        req_valid,
  input logic                        req_write,
  input logic [13:0]                 req_addr,
  input logic                        rsp_valid,
  input logic [WR_CH-1:0][8:0][31:0] wr_cfg,
  input logic [RD_CH-1:0][8:0][31:0] rd_cfg,
  input logic [WR_CH-1:0]            wr_start,
  input logic [WR_CH-1:0]            wr_abort,
  input logic [RD_CH-1:0]            rd_start,
  input logic [RD_CH-1:0]            rd_abort,
  input logic [WR_CH-1:0]            wr_done_evt,
  input logic [1:0]                  eng_en,
  input logic [31:0]                 wr_stat,
  input logic [31:0]                 rd_stat,
  input logic                        wr_irq,
  input logic                        rd_irq
);

  AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && !req_write)); // R2

  AST_VP_BLOCKS_FLAT: assert property (@(posedge clk) disable iff (!rst_n)
    (!map_unrolled && req_valid && req_write && req_addr[13:12] != 2'b00)
      |=> ($stable(wr_cfg) && $stable(rd_cfg))); // R4

  AST_WR_PULSE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_start, wr_abort})); // R6

  AST_RD_PULSE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_start, rd_abort})); // R6

  AST_WR_PULSE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (|{wr_start, wr_abort}) |-> $past(eng_en[0] && req_valid && req_write)); // R7

  AST_RD_PULSE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (|{rd_start, rd_abort}) |-> $past(eng_en[1] && req_valid && req_write)); // R7

  AST_DONE_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (|wr_done_evt) |=> ((wr_stat[WR_CH-1:0] & $past(wr_done_evt)) == $past(wr_done_evt))); // R8

  AST_WR_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat == 32'd0) |-> !wr_irq); // R10

  AST_RD_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat == 32'd0) |-> !rd_irq); // R10

endmodule

bind dmareg_bank dmareg_bank_chk #(.WR_CH(WR_CH), .RD_CH(RD_CH)) i_chk (
  .clk(clk), .rst_n(rst_n), .map_unrolled(map_unrolled), .req_valid(req_valid),
  .req_write(req_write), .req_addr(req_addr), .rsp_valid(rsp_valid),
  .wr_cfg(wr_cfg), .rd_cfg(rd_cfg), .wr_start(wr_start), .wr_abort(wr_abort),
  .rd_start(rd_start), .rd_abort(rd_abort), .wr_done_evt(wr_done_evt),
  .eng_en(eng_en), .wr_stat(wr_stat), .rd_stat(rd_stat),
  .wr_irq(wr_irq), .rd_irq(rd_irq)
);

// File: tb/test_dmareg_bank.sv
`timescale 1ns/1ps
module test_dmareg_bank;

  localparam int WR_CH = 8;
  localparam int RD_CH = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic map_unrolled = 1'b1;
  logic req_valid = 1'b0;
  logic req_write = 1'b0;
  logic [13:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic rsp_valid;
  logic [31:0] rsp_rdata;
  logic [WR_CH-1:0][8:0][31:0] wr_cfg;
  logic [RD_CH-1:0][8:0][31:0] rd_cfg;
  logic [WR_CH-1:0] wr_start, wr_abort;
  logic [RD_CH-1:0] rd_start, rd_abort;
  logic [WR_CH-1:0] wr_done_evt = '0, wr_abort_evt = '0;
  logic [RD_CH-1:0] rd_done_evt = '0, rd_abort_evt = '0;
  logic wr_irq, rd_irq;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  dmareg_bank #(.WR_CH(WR_CH), .RD_CH(RD_CH)) i_dmareg_bank (
    .clk(clk), .rst_n(rst_n), .map_unrolled(map_unrolled),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .wr_cfg(wr_cfg), .rd_cfg(rd_cfg), .wr_start(wr_start), .wr_abort(wr_abort),
    .rd_start(rd_start), .rd_abort(rd_abort), .wr_done_evt(wr_done_evt),
    .wr_abort_evt(wr_abort_evt), .rd_done_evt(rd_done_evt),
    .rd_abort_evt(rd_abort_evt), .wr_irq(wr_irq), .rd_irq(rd_irq)
  );

  // Flat-map address: slot 0-7 write, 8-15 read, stride 0x200
  function automatic logic [13:0] flat(input int slot, input int k);
    return 14'(32'h1000 + slot * 32'h200 + k * 4);
  endfunction

  typedef struct packed {
    logic        is_rd;
    logic [13:0] addr;
    logic [31:0] data;  // write data, or expected read data
    logic [3:0]  req;
  } vec_t;

  // R2 flat map writes and reads, R5 unimplemented read channel 6
  localparam vec_t VEC [14] = '{
    '{1'b0, 14'h1000, 32'hA5A5_0001, 4'd2},
    '{1'b0, 14'h1E20, 32'h1234_5678, 4'd2},
    '{1'b0, 14'h200C, 32'hCAFE_0003, 4'd2},
    '{1'b0, 14'h2A14, 32'h0BAD_F00D, 4'd2},
    '{1'b0, 14'h2C00, 32'hDEAD_BEEF, 4'd5},
    '{1'b0, 14'h1010, 32'h0000_00FF, 4'd2},
    '{1'b1, 14'h1000, 32'hA5A5_0001, 4'd2},
    '{1'b1, 14'h1E20, 32'h1234_5678, 4'd2},
    '{1'b1, 14'h200C, 32'hCAFE_0003, 4'd2},
    '{1'b1, 14'h2A14, 32'h0BAD_F00D, 4'd2},
    '{1'b1, 14'h2C00, 32'h0000_0000, 4'd5},
    '{1'b1, 14'h1010, 32'h0000_00FF, 4'd2},
    '{1'b1, 14'h100C, 32'h0000_0000, 4'd2},
    '{1'b1, 14'h1024, 32'h0000_0000, 4'd2}
  };

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [13:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic bus_rd(input logic [13:0] a, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    n_chk++;
    if (rsp_valid !== 1'b1) begin
      n_err++;
      $display("FAIL R2 rsp_valid actual=%b expected=1", rsp_valid);
    end
    d = rsp_rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL R1 watchdog actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] got;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 cfg zero", 32'(wr_cfg != '0 || rd_cfg != '0), 32'd0);
    chk("R1 outputs idle", 32'({rsp_valid, wr_irq, rd_irq, |wr_start, |rd_start}), 32'd0);
    rst_n = 1'b1;
    bus_rd(14'h0008, got);
    chk("R1 status zero", got, 32'd0);

    for (int i = 0; i < 14; i++) begin
      if (VEC[i].is_rd) begin
        bus_rd(VEC[i].addr, got);
        chk($sformatf("R%0d table row %0d", VEC[i].req, i), got, VEC[i].data);
      end else begin
        bus_wr(VEC[i].addr, VEC[i].data);
      end
    end
    chk("R2 wr_cfg ch0 control1", wr_cfg[0][0], 32'hA5A5_0001);
    chk("R2 rd_cfg ch5 dst low", rd_cfg[5][5], 32'h0BAD_F00D);
    chk("R2 wr_cfg ch7 list high", wr_cfg[7][8], flat(7, 8) == 14'h1E20 ? 32'h1234_5678 : 32'h0);

    // R3 viewport
    map_unrolled = 1'b0;
    bus_wr(14'h0040, 32'h8000_0002);
    bus_rd(14'h0040, got);
    chk("R3 selector readback", got, 32'h8000_0002);
    bus_wr(14'h0108, 32'h5555_0002);
    chk("R3 rd_cfg ch2 size", rd_cfg[2][2], 32'h5555_0002);
    bus_rd(14'h0108, got);
    chk("R3 window read", got, 32'h5555_0002);
    bus_wr(14'h0040, 32'h0000_0000);
    bus_rd(14'h0100, got);
    chk("R3 window write ch0 control1", got, 32'hA5A5_0001);
    bus_wr(14'h0040, 32'h8000_0007);
    bus_wr(14'h0100, 32'h0000_1111);
    bus_rd(14'h0100, got);
    chk("R5 window unimplemented ch", got, 32'd0);

    // R4 mode isolation
    bus_wr(14'h1000, 32'h0000_FFFF);
    chk("R4 flat write ignored in viewport", wr_cfg[0][0], 32'hA5A5_0001);
    bus_rd(14'h1000, got);
    chk("R4 flat read zero in viewport", got, 32'd0);
    map_unrolled = 1'b1;
    bus_wr(14'h0040, 32'h8000_0002);
    bus_wr(14'h0108, 32'h0000_0077);
    chk("R4 window write ignored in flat", rd_cfg[2][2], 32'h5555_0002);
    bus_rd(14'h0108, got);
    chk("R4 window read zero in flat", got, 32'd0);

    // R7 doorbell with engine off, R6 with engine on
    bus_wr(14'h0004, 32'h0000_0003);
    chk("R7 no pulse when disabled", 32'({wr_start, wr_abort}), 32'd0);
    bus_wr(14'h0000, 32'h0000_0001);
    bus_rd(14'h0000, got);
    chk("R6 engine enable readback", got, 32'd1);
    bus_wr(14'h0004, 32'h0000_0003);
    chk("R6 start pulse ch3", 32'(wr_start), 32'h08);
    chk("R6 no abort", 32'(wr_abort), 32'd0);
    @(negedge clk);
    chk("R6 pulse one cycle", 32'(wr_start), 32'd0);
    bus_wr(14'h0004, 32'h8000_0005);
    chk("R6 abort pulse ch5", 32'(wr_abort), 32'h20);
    chk("R6 abort without start", 32'(wr_start), 32'd0);
    bus_rd(14'h0004, got);
    chk("R6 doorbell reads zero", got, 32'd0);
    bus_wr(14'h0020, 32'h0000_0001);
    bus_wr(14'h0024, 32'h0000_0007);
    chk("R5 no pulse unimplemented rd ch", 32'({rd_start, rd_abort}), 32'd0);
    bus_wr(14'h0024, 32'h0000_0004);
    chk("R6 read start ch4", 32'(rd_start), 32'h10);

    // R8 status, R10 mask, R9 clear
    @(negedge clk);
    wr_done_evt = 8'h08; wr_abort_evt = 8'h02;
    @(negedge clk);
    wr_done_evt = '0; wr_abort_evt = '0;
    chk("R10 irq unmasked", 32'(wr_irq), 32'd1);
    bus_rd(14'h0008, got);
    chk("R8 status bits", got, 32'h0002_0008);
    bus_wr(14'h000C, 32'h0002_0008);
    chk("R10 irq all masked", 32'(wr_irq), 32'd0);
    bus_wr(14'h000C, 32'h0000_0008);
    chk("R10 irq abort unmasked", 32'(wr_irq), 32'd1);
    bus_wr(14'h0010, 32'h0002_0000);
    bus_rd(14'h0008, got);
    chk("R9 clear abort bit", got, 32'h0000_0008);
    chk("R10 irq remaining masked", 32'(wr_irq), 32'd0);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 14'h0010; req_wdata = 32'h8;
    wr_done_evt = 8'h08;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; wr_done_evt = '0;
    bus_rd(14'h0008, got);
    chk("R9 set beats same-cycle clear", got, 32'h0000_0008);
    bus_wr(14'h0010, 32'hFFFF_FFFF);
    bus_rd(14'h0008, got);
    chk("R9 clear all", got, 32'd0);
    bus_rd(14'h0010, got);
    chk("R9 clear reads zero", got, 32'd0);
    @(negedge clk);
    rd_done_evt = 6'h20;
    @(negedge clk);
    rd_done_evt = '0;
    chk("R10 read irq", 32'(rd_irq), 32'd1);
    bus_rd(14'h0028, got);
    chk("R8 read status", got, 32'h0000_0020);

    // R1 reset again
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 cfg cleared", 32'(wr_cfg != '0 || rd_cfg != '0), 32'd0);
    chk("R1 irq cleared", 32'({wr_irq, rd_irq}), 32'd0);
    rst_n = 1'b1;
    bus_rd(14'h0000, got);
    chk("R1 engine enable cleared", got, 32'd0);
    bus_rd(14'h0040, got);
    chk("R1 selector cleared", got, 32'd0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule